// File: doc/BRIEF.md
# Configurable Bidirectional I/O Port

An eight-pin bidirectional port that a microcontroller controls through four byte-wide registers on a simple read/write strobe bus. Each pin has its own mode bit. A pin in register mode is driven from a software-written output latch. A pin in logic mode is driven from an external logic-array output. In both modes the level on the pin is synchronised and can be read back by software. The same synchronised value is also forwarded to the logic array.

Each pin's output enable is the OR of a software direction bit and an external enable term. The enable term lets outside logic take over the driver without software. A pin can be marked externally as a logic-array input. If software then sets that pin's direction bit, a conflict flag is raised for the pin. A build parameter removes the mode register entirely. In that build every pin stays in register mode.

Top module: `cfg_io_port`

## Requirements
- R1: A mode bit of 0 makes the pin carry its Data Out bit on `pad_out`. A mode bit of 1 makes it carry the matching `la_out` bit instead. The mode register is at offset 1, and bit i belongs to pin i.
- R2: A direction bit of 1 makes the pin an output (`pad_oe` high). A direction bit of 0 leaves the pin undriven unless the external enable is high. The direction register is at offset 3.
- R3: `pad_oe[i]` is the OR of direction bit i and `la_oe[i]`. A pin in logic mode therefore has no driver only when both are 0.
- R4: A write to offset 2 (Data Out) is sampled at a clock edge and appears on `pad_out` of register-mode pins directly after that edge.
- R5: `pad_in` passes through two flops before it reaches the read path. A read at offset 0 returns a pad level that was held for two edges before the edge that samples the read strobe.
- R6: When the parameter `HAS_MODE_REG` is 0, writes to offset 1 have no effect, offset 1 reads as 0, and every pin stays in register mode.
- R7: `dir_conflict[i]` is high whenever direction bit i is 1 while `la_in_mark[i]` is 1, and is low otherwise.
- R8: The bus is word-addressed with 2-bit offsets: 0 = Data In (read only), 1 = mode, 2 = Data Out, 3 = direction. Read data appears on `bus_rdata` one clock after the read strobe is sampled, and it holds between reads.
- R9: After reset, all writable registers and `bus_rdata` are 0. Every pin is then a register-mode input, undriven while `la_oe` is 0.
- R10: Writes to offset 0 change no register.
- R11: `la_in` carries the same two-flop synchronised pad value that Data In reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, registered |
| la_out | input | W | Logic-array output per pin |
| la_oe | input | W | External output-enable term per pin |
| la_in_mark | input | W | Pin is used as a logic-array input |
| la_in | output | W | Synchronised pad value to the logic array |
| pad_in | input | W | Raw pad level |
| pad_out | output | W | Pad output value |
| pad_oe | output | W | Pad output enable |
| dir_conflict | output | W | Direction set on a logic-input pin |

## Verification
Register writes take effect at the edge that samples the strobe. Their effect on `pad_out`, `pad_oe` and `dir_conflict` is checked at the falling edge that follows. Changes on `la_out`, `la_oe` and `la_in_mark` reach the outputs without a clock, so they are checked at the same falling edge at which they are driven. A new pad level is checked on `la_in` after two rising edges. It is checked through a Data In read only after it has been held three edges, and every read result is compared at the falling edge after its strobe's sampling edge.

// File: rtl/cfg_io_port.sv
module cfg_io_port #(
  parameter int W            = 8,
  parameter bit HAS_MODE_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] la_out,
  input  logic [W-1:0] la_oe,
  input  logic [W-1:0] la_in_mark,
  output logic [W-1:0] la_in,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] dir_conflict
);
  localparam logic [1:0] OFS_DIN  = 2'd0;
  localparam logic [1:0] OFS_MODE = 2'd1;
  localparam logic [1:0] OFS_DOUT = 2'd2;
  localparam logic [1:0] OFS_DIR  = 2'd3;

  logic [W-1:0] mode_q, dout_q, dir_q;
  logic [W-1:0] sync1_q, sync2_q;
  logic [W-1:0] rd_mux;

  generate
    if (HAS_MODE_REG) begin : g_mode
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) mode_q <= '0;
        else if (bus_wr && bus_addr == OFS_MODE) mode_q <= bus_wdata;
    end else begin : g_nomode
      assign mode_q = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_DOUT) dout_q <= bus_wdata;
      if (bus_addr == OFS_DIR)  dir_q  <= bus_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end

  always_comb
    case (bus_addr)
      OFS_DIN:  rd_mux = sync2_q;
      OFS_MODE: rd_mux = mode_q;
      OFS_DOUT: rd_mux = dout_q;
      default:  rd_mux = dir_q;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;

  assign pad_oe       = dir_q | la_oe;
  assign pad_out      = (mode_q & la_out) | (~mode_q & dout_q);
  assign la_in        = sync2_q;
  assign dir_conflict = dir_q & la_in_mark;

  // R2/R3: a direction write forces the written bits to drive on the next cycle
  a_r3_dir_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DIR) |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata)));

  // R4: Data Out write reaches register-mode pins right after the edge
  a_r4_dout_to_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DOUT && mode_q == '0) |=> (pad_out == $past(bus_wdata)));

  // R5/R8: Data In read returns the synchronised level one clock later
  a_r5_din_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_DIN) |=> (bus_rdata == $past(la_in)));

  // R8: read data holds between reads
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R10: writes to the Data In offset leave state alone
  a_r10_din_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DIN) |=> (dir_q == $past(dir_q) && dout_q == $past(dout_q) && mode_q == $past(mode_q)));

  generate
    if (!HAS_MODE_REG) begin : g_chk_nomode
      // R6: without the mode register every pin follows Data Out
      a_r6_always_mcu: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MODE) |=> (pad_out == dout_q));
    end
  endgenerate
endmodule

// File: tb/test_cfg_io_port.sv
module test_cfg_io_port;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, la_out = 0, la_oe = 0, la_in_mark = 0, pad_in = 0;
  logic [W-1:0] rdata_a, la_in_a, pad_out_a, pad_oe_a, conf_a;
  logic [W-1:0] rdata_b, la_in_b, pad_out_b, pad_oe_b, conf_b;
  logic [W-1:0] m_mode = 0, m_dout = 0, m_dir = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_io_port #(.W(W), .HAS_MODE_REG(1'b1)) i_cfg_io_port (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata(rdata_a),
    .la_out, .la_oe, .la_in_mark, .la_in(la_in_a), .pad_in,
    .pad_out(pad_out_a), .pad_oe(pad_oe_a), .dir_conflict(conf_a));

  cfg_io_port #(.W(W), .HAS_MODE_REG(1'b0)) i_cfg_io_port_nomode (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata(rdata_b),
    .la_out, .la_oe, .la_in_mark, .la_in(la_in_b), .pad_in,
    .pad_out(pad_out_b), .pad_oe(pad_oe_b), .dir_conflict(conf_b));

  function automatic logic [W-1:0] exp_out(input logic [W-1:0] md, dq, lo);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = md[i] ? lo[i] : dq[i];
    return r;
  endfunction

  function automatic logic [W-1:0] exp_reg(input logic [1:0] a, input logic [W-1:0] md, input logic [W-1:0] din);
    case (a)
      2'd0: return din;
      2'd1: return md;
      2'd2: return m_dout;
      default: return m_dir;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    if (a == 2'd1) m_mode = d;
    if (a == 2'd2) m_dout = d;
    if (a == 2'd3) m_dir  = d;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [W-1:0] din);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    check("R8 read A", rdata_a, exp_reg(a, m_mode, din));
    check("R6 read B", rdata_b, exp_reg(a, '0, din));
  endtask

  task automatic check_pins();
    check("R1/R4 pad_out", pad_out_a, exp_out(m_mode, m_dout, la_out));
    check("R3/R2 pad_oe", pad_oe_a, m_dir | la_oe);
    check("R7 conflict", conf_a, m_dir & la_in_mark);
    check("R6 pad_out no-mode", pad_out_b, m_dout);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 rdata", rdata_a, '0);
    check("R9 pad_oe", pad_oe_a, '0);
    check("R9 pad_out", pad_out_a, '0);
    rst_n = 1;
    @(negedge clk);
    check_pins();

    // R1: directed mode selection
    la_out = 8'hA5;
    bus_write(2'd2, 8'h3C);
    bus_write(2'd1, 8'hF0);
    check("R1 mixed modes", pad_out_a, 8'hA4 | 8'h0C);
    // R2/R3: direction and external enable
    bus_write(2'd3, 8'h81);
    la_oe = 8'h18;
    #1 check("R3 oe OR", pad_oe_a, 8'h99);
    la_oe = 8'h00;
    #1 check("R3 logic pin tri-stated", pad_oe_a & 8'h70, 8'h00);
    // R7: conflict
    la_in_mark = 8'h03;
    #1 check("R7 conflict bit0", conf_a, 8'h01);
    // R10: write to offset 0 ignored
    bus_write(2'd0, 8'hFF);
    m_mode = 8'hF0; m_dout = 8'h3C; m_dir = 8'h81;
    check_pins();
    for (int a = 1; a < 4; a++) bus_read(a[1:0], '0);
    // R6: mode write has no effect on the no-mode variant
    bus_write(2'd1, 8'hFF);
    check("R6 no-mode follows dout", pad_out_b, m_dout);
    bus_read(2'd1, '0);
    // R5/R11: data-in path
    pad_in = 8'h5A;
    @(negedge clk);
    check("R5 not yet visible after one edge", la_in_a, 8'h00);
    @(negedge clk);
    check("R11 la_in", la_in_a, 8'h5A);
    @(negedge clk);
    bus_read(2'd0, 8'h5A);

    // random phase
    for (int it = 0; it < 300; it++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      la_out = W'($urandom); la_oe = W'($urandom); la_in_mark = W'($urandom);
      if ($urandom_range(0, 3) == 0) la_oe = '0;
      bus_write(op, W'($urandom));
      check_pins();
      if (it % 5 == 0) begin
        pad_in = W'($urandom);
        repeat (3) @(negedge clk);
        check("R11 la_in rnd", la_in_b, pad_in);
        bus_read(2'($urandom_range(0, 3)), pad_in);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule